// File: doc/BRIEF.md
# Multi-Mode Effective Address Generator

This unit computes the memory address for one load or store request per cycle in a load/store pipeline. Each request carries a mode code, a base register value and its register number, an index register value, an immediate displacement with a width code, a scale code, an access-size code and the program counter. The block forms the address from these operands and registers the result. It supports eight addressing modes: absolute, register-indirect, base plus displacement, base plus index, scaled index, PC-relative, post-increment, and pre-indexed update.

The two update modes also produce a new value for the base register. The block raises a writeback strobe for that value and returns the register number that came with the request. Results appear one clock after the request, with a valid flag. All arithmetic wraps modulo the address width, and overflow is not reported.

Top module: `eag_top`

## Requirements
- R1: `ea_valid` is high exactly one clock after a cycle in which `req_valid` was high, and low otherwise. While `rst_n` is low, `ea_valid` and `wb_en` are low.
- R2: The displacement is sign-extended to the address width before use. With `req_disp_size` = 0 only bits 7:0 count, with 1 only bits 15:0 count, and with 2 or 3 all bits count.
- R3: Mode 0 (absolute) gives an address equal to the extended displacement alone.
- R4: Mode 1 (register-indirect) gives an address equal to the base value.
- R5: Mode 2 (displacement) gives base plus the extended displacement.
- R6: Mode 3 (base plus index) gives base plus index, and the displacement has no effect.
- R7: Mode 4 (scaled) gives base + index × 2^`req_scale` + the extended displacement. Scale codes 0..3 mean factors 1, 2, 4 and 8.
- R8: Mode 5 (PC-relative) gives `req_pc` plus the extended displacement, and the base value has no effect.
- R9: Mode 6 (post-increment) gives an address equal to the unmodified base. It raises `wb_en`, with `wb_data` = base + 2^`req_acc_size` bytes and `wb_reg` = `req_base_reg`.
- R10: Mode 7 (pre-indexed update) gives base plus the extended displacement. It raises `wb_en`, with `wb_data` equal to that same address and `wb_reg` = `req_base_reg`.
- R11: `wb_en` stays low for modes 0 to 5 and in any cycle that carries no valid result.
- R12: Every sum wraps modulo 2^AW, with no overflow indication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_mode | input | 3 | Addressing mode code 0..7 |
| req_base | input | AW | Base register value |
| req_index | input | AW | Index register value |
| req_disp | input | AW | Immediate displacement (low bits used per size code) |
| req_disp_size | input | 2 | Displacement width: 0 = 8-bit, 1 = 16-bit, 2/3 = full |
| req_scale | input | 2 | Index shift amount 0..3 |
| req_acc_size | input | 2 | log2 of the access size in bytes, used by post-increment |
| req_pc | input | AW | Program counter of the requesting instruction |
| req_base_reg | input | RW | Register number of the base operand |
| ea_valid | output | 1 | Result valid |
| ea_addr | output | AW | Effective address |
| wb_en | output | 1 | Base register writeback strobe |
| wb_reg | output | RW | Register number to update |
| wb_data | output | AW | New base register value |

## Verification
In the update modes, the address and the base writeback leave the block in the same output cycle. In post-increment mode the two values must differ by exactly the access size. In pre-indexed mode they must be equal. The bench sends update-mode requests back to back and mixes them with the other modes. Each cycle it compares the address, the strobe, the register number and the written value with its own model, and it includes sums that wrap past the top of the address space.

// File: rtl/eag_pkg.sv
package eag_pkg;
  typedef enum logic [2:0] {
    MODE_ABS     = 3'd0,
    MODE_REGIND  = 3'd1,
    MODE_DISP    = 3'd2,
    MODE_BIDX    = 3'd3,
    MODE_SCALED  = 3'd4,
    MODE_PCREL   = 3'd5,
    MODE_POSTINC = 3'd6,
    MODE_PREIDX  = 3'd7
  } eag_mode_e;

  localparam logic [1:0] DSZ_8  = 2'd0;
  localparam logic [1:0] DSZ_16 = 2'd1;

  function automatic logic is_update_mode(input logic [2:0] m);
    return (m == MODE_POSTINC) || (m == MODE_PREIDX);
  endfunction
endpackage

// File: rtl/eag_disp_ext.sv
module eag_disp_ext #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] disp_raw,
  input  logic [1:0]    disp_size,
  output logic [AW-1:0] disp_ext
);
  import eag_pkg::*;

  localparam int PAD8  = AW - 8;
  localparam int PAD16 = AW - 16;

  always_comb begin
    case (disp_size)
      DSZ_8:   disp_ext = {{PAD8{disp_raw[7]}}, disp_raw[7:0]};
      DSZ_16:  disp_ext = {{PAD16{disp_raw[15]}}, disp_raw[15:0]};
      default: disp_ext = disp_raw;
    endcase
  end
endmodule

// File: rtl/eag_calc.sv
module eag_calc #(
  parameter int AW = 32
) (
  input  logic [2:0]    mode,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] index,
  input  logic [AW-1:0] disp,
  input  logic [1:0]    scale,
  input  logic [1:0]    acc_size,
  input  logic [AW-1:0] pc,
  output logic [AW-1:0] addr,
  output logic [AW-1:0] wb_val,
  output logic          wb_is_update
);
  import eag_pkg::*;

  function automatic logic [AW-1:0] scale_index(input logic [AW-1:0] x, input logic [1:0] sh);
    return x << sh;
  endfunction

  function automatic logic [AW-1:0] step_bytes(input logic [1:0] lg);
    return {{(AW-1){1'b0}}, 1'b1} << lg;
  endfunction

  logic [AW-1:0] base_term;
  logic [AW-1:0] idx_term;
  logic [AW-1:0] disp_term;
  logic [AW-1:0] scaled_idx;
  logic [AW-1:0] post_val;

  assign scaled_idx = scale_index(index, scale);
  assign post_val   = base + step_bytes(acc_size);

  always_comb begin
    case (mode)
      MODE_ABS:   base_term = '0;
      MODE_PCREL: base_term = pc;
      default:    base_term = base;
    endcase
  end

  always_comb begin
    case (mode)
      MODE_BIDX:   idx_term = index;
      MODE_SCALED: idx_term = scaled_idx;
      default:     idx_term = '0;
    endcase
  end

  always_comb begin
    case (mode)
      MODE_ABS, MODE_DISP, MODE_SCALED, MODE_PCREL, MODE_PREIDX: disp_term = disp;
      default: disp_term = '0;
    endcase
  end

  assign addr         = base_term + idx_term + disp_term;
  assign wb_is_update = is_update_mode(mode);
  assign wb_val       = (mode == MODE_POSTINC) ? post_val : addr;
endmodule

// File: rtl/eag_top.sv
module eag_top #(
  parameter int AW = 32,
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    req_mode,
  input  logic [AW-1:0] req_base,
  input  logic [AW-1:0] req_index,
  input  logic [AW-1:0] req_disp,
  input  logic [1:0]    req_disp_size,
  input  logic [1:0]    req_scale,
  input  logic [1:0]    req_acc_size,
  input  logic [AW-1:0] req_pc,
  input  logic [RW-1:0] req_base_reg,
  output logic          ea_valid,
  output logic [AW-1:0] ea_addr,
  output logic          wb_en,
  output logic [RW-1:0] wb_reg,
  output logic [AW-1:0] wb_data
);
  import eag_pkg::*;

  logic [AW-1:0] disp_ext;
  logic [AW-1:0] calc_addr;
  logic [AW-1:0] calc_wb;
  logic          calc_upd;

  eag_disp_ext #(.AW(AW)) u_ext (
    .disp_raw  (req_disp),
    .disp_size (req_disp_size),
    .disp_ext  (disp_ext)
  );

  eag_calc #(.AW(AW)) u_calc (
    .mode         (req_mode),
    .base         (req_base),
    .index        (req_index),
    .disp         (disp_ext),
    .scale        (req_scale),
    .acc_size     (req_acc_size),
    .pc           (req_pc),
    .addr         (calc_addr),
    .wb_val       (calc_wb),
    .wb_is_update (calc_upd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ea_valid <= 1'b0;
      wb_en    <= 1'b0;
      ea_addr  <= '0;
      wb_reg   <= '0;
      wb_data  <= '0;
    end else begin
      ea_valid <= req_valid;
      wb_en    <= req_valid && calc_upd;
      if (req_valid) begin
        ea_addr <= calc_addr;
        wb_data <= calc_wb;
        wb_reg  <= req_base_reg;
      end
    end
  end

  // R1: one-cycle result latency
  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ea_valid == $past(req_valid));

  // R3: absolute with full-width displacement returns it unchanged
  assert_abs_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && req_mode == MODE_ABS && req_disp_size[1]) |-> ea_addr == $past(req_disp));

  // R4: register-indirect returns the base
  assert_regind_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && req_mode == MODE_REGIND) |-> ea_addr == $past(req_base));

  // R9: post-increment writes back base plus access size, address is base
  assert_postinc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && req_mode == MODE_POSTINC) |->
      wb_en && ea_addr == $past(req_base) &&
      (wb_data - ea_addr) == ({{(AW-1){1'b0}}, 1'b1} << $past(req_acc_size)));

  // R10: pre-indexed update writes back the address itself
  assert_preidx_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && req_mode == MODE_PREIDX) |-> wb_en && wb_data == ea_addr &&
      wb_reg == $past(req_base_reg));

  // R11: no writeback without an update-mode result
  assert_no_wb_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req_valid && (req_mode == MODE_POSTINC || req_mode == MODE_PREIDX)) |-> !wb_en);

  // R11: a writeback strobe always accompanies a valid result
  assert_wb_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> ea_valid);
endmodule

// File: tb/eag_top_tb.sv
module eag_top_tb;
  localparam int AW = 32;
  localparam int RW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [2:0]    req_mode = '0;
  logic [AW-1:0] req_base = '0;
  logic [AW-1:0] req_index = '0;
  logic [AW-1:0] req_disp = '0;
  logic [1:0]    req_disp_size = '0;
  logic [1:0]    req_scale = '0;
  logic [1:0]    req_acc_size = '0;
  logic [AW-1:0] req_pc = '0;
  logic [RW-1:0] req_base_reg = '0;
  logic          ea_valid;
  logic [AW-1:0] ea_addr;
  logic          wb_en;
  logic [RW-1:0] wb_reg;
  logic [AW-1:0] wb_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  eag_top #(.AW(AW), .RW(RW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .req_base(req_base), .req_index(req_index), .req_disp(req_disp),
    .req_disp_size(req_disp_size), .req_scale(req_scale), .req_acc_size(req_acc_size),
    .req_pc(req_pc), .req_base_reg(req_base_reg), .ea_valid(ea_valid), .ea_addr(ea_addr),
    .wb_en(wb_en), .wb_reg(wb_reg), .wb_data(wb_data)
  );

  function automatic longint sext(input longint d, input int sz);
    longint r;
    if (sz == 0) begin
      r = d % 256;
      if (r >= 128) r = r - 256;
    end else if (sz == 1) begin
      r = d % 65536;
      if (r >= 32768) r = r - 65536;
    end else r = d;
    return r;
  endfunction

  function automatic longint wrap(input longint v);
    longint m = longint'(1) << AW;
    longint r = v % m;
    if (r < 0) r = r + m;
    return r;
  endfunction

  function automatic string tag_of(input int m);
    case (m)
      0: return "R3"; 1: return "R4"; 2: return "R5"; 3: return "R6";
      4: return "R7"; 5: return "R8"; 6: return "R9"; default: return "R10";
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Drive one request (or idle) at a falling edge, then check one cycle later.
  task automatic step(input bit v, input int m, input longint b, input longint x,
                      input longint d, input int dsz, input int sc, input int acc,
                      input longint p, input int rg, input string tag);
    longint dd, e, w;
    bit upd;
    req_valid = v; req_mode = 3'(m); req_base = AW'(b); req_index = AW'(x);
    req_disp = AW'(d); req_disp_size = 2'(dsz); req_scale = 2'(sc);
    req_acc_size = 2'(acc); req_pc = AW'(p); req_base_reg = RW'(rg);
    dd = sext(d, dsz);
    w = 0; upd = 0;
    case (m)
      0: e = dd;
      1: e = b;
      2: e = b + dd;
      3: e = b + x;
      4: e = b + x * (longint'(1) << sc) + dd;
      5: e = p + dd;
      6: begin e = b; w = b + (longint'(1) << acc); upd = 1; end
      default: begin e = b + dd; w = e; upd = 1; end
    endcase
    e = wrap(e); w = wrap(w);
    @(negedge clk);
    chk("R1", "ea_valid", longint'(ea_valid), longint'(v));
    if (!v) chk("R11", "wb_en idle", longint'(wb_en), 0);
    else begin
      chk(tag, "ea_addr", longint'(ea_addr), e);
      chk(upd ? tag : "R11", "wb_en", longint'(wb_en), longint'(upd));
      if (upd) begin
        chk(tag, "wb_data", longint'(wb_data), w);
        chk(tag, "wb_reg", longint'(wb_reg), longint'(rg));
      end
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset ea_valid", longint'(ea_valid), 0);
    chk("R1", "reset wb_en", longint'(wb_en), 0);
    rst_n = 1'b1;
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
    // R2 / R3: sign extension per size code
    step(1, 0, 'h1234, 0, 'hABCD_EF80, 0, 0, 0, 0, 1, "R2");
    step(1, 0, 'h1234, 0, 'hABCD_8001, 1, 0, 0, 0, 1, "R2");
    step(1, 0, 'h1234, 0, 'h7FFF_FF7F, 2, 0, 0, 0, 1, "R3");
    step(1, 0, 0, 0, 'h0000_007F, 0, 0, 0, 0, 1, "R2");
    step(1, 1, 'hDEAD_BEEF, 5, 9, 2, 0, 0, 0, 2, "R4");
    step(1, 2, 'h1000, 0, 'hFFF0, 1, 0, 0, 0, 2, "R5");
    // R6: displacement ignored
    step(1, 3, 'h100, 'h20, 'h5555_5555, 2, 3, 0, 0, 3, "R6");
    // R7: each scale
    for (int s = 0; s < 4; s++) step(1, 4, 'h4000, 'h13, 'hFC, 0, s, 0, 0, 4, "R7");
    // R8: base ignored
    step(1, 5, 'hFFFF_FFFF, 0, 'h80, 0, 0, 0, 'h0000_2000, 0, "R8");
    // R9 back to back with each access size
    for (int a = 0; a < 4; a++) step(1, 6, 'h8000 + a, 0, 'h44, 2, 0, a, 0, 7 + a, "R9");
    step(1, 7, 'h8000, 0, 'hF8, 0, 0, 0, 0, 31, "R10");
    step(1, 6, 'hFFFF_FFFE, 0, 0, 2, 0, 3, 0, 12, "R12");
    step(1, 7, 'hFFFF_FFF0, 0, 'h20, 2, 0, 0, 0, 13, "R12");
    step(1, 4, 'hFFFF_FF00, 'h8000_0000, 'h100, 2, 3, 0, 0, 4, "R12");
    step(1, 5, 0, 0, 'hFFFF, 1, 0, 0, 'h0, 0, "R12");
    step(0, 7, 1, 1, 1, 0, 0, 0, 0, 0, "R11");
    for (int i = 0; i < 400; i++) begin
      int m = int'($urandom_range(0, 7));
      bit v = ($urandom_range(0, 7) != 0);
      step(v, m, longint'($urandom), longint'($urandom), longint'($urandom),
           int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
           int'($urandom_range(0, 3)), longint'($urandom),
           int'($urandom_range(0, 31)), tag_of(m));
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule